// File: doc/BRIEF.md
# Trimmable Nanosecond Time Counter

This block keeps a running nanosecond count for hardware time stamping. It is clocked by a reference clock. While enabled, it adds a programmable step to the count on every cycle. To trim the rate finely, a second programmable step replaces the normal one on every Nth running cycle. The count can wrap back at a programmable limit, or it can run through the full counter width. Software can load the count directly, restart it from zero, or request a coherent snapshot of it and read that snapshot back.

Control goes through a small word-addressed write port and a combinational read port. The address map is: 0 control, 1 value, 2 wrap limit, 3 correction interval, 4 steps. The live count and the snapshot are outputs. So are a one-cycle wrap pulse and a gated event pulse, which compare logic elsewhere can use.

Top module: `ptp_ns_timer`

## Requirements
- R1: After reset the count, the snapshot, both pulses and every register read back as zero.
- R2: Control bit 0 enables counting. A write to it takes effect from the following clock edge. While it is clear, the count holds unless a load or restart is written.
- R3: On each running cycle the count grows by the normal step held in bits 6:0 of the step register (address 4).
- R4: When the correction interval register (address 3) holds K other than zero, every (K+1)th running cycle adds the correction step from bits 14:8 of address 4 in place of the normal step.
- R5: A correction interval of zero disables correction, so only the normal step is added.
- R6: A write to address 3 restarts the correction phase. The first correction then falls on the (K+1)th running cycle after that write.
- R7: With control bits 4 and 5 both set, a step that would bring the count to or past the wrap limit (address 2) leaves count + step − limit instead. wrap_o pulses for one cycle together with the wrapped count.
- R8: If either bit 4 or bit 5 is clear, the count never wraps at the limit. It rolls over modulo 2^CNT_W, and wrap_o stays low.
- R9: evt_o pulses together with wrap_o only while control bit 7 is set. Otherwise it stays low.
- R10: A write to address 1 loads the count at that edge and takes precedence over the step for that cycle.
- R11: A control write with bit 9 set zeroes the count at that edge. Bit 9 always reads back as 0.
- R12: A control write with bit 11 set latches the count into the snapshot on the next edge. The snapshot drives cap_o and is returned by a read of address 1. Bit 11 reads 1 only for the single pending cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | CNT_W | Read data for rd_addr (combinational) |
| cnt_o | output | CNT_W | Live nanosecond count |
| wrap_o | output | 1 | One-cycle pulse when the count wraps at the limit |
| evt_o | output | 1 | Wrap pulse gated by control bit 7 |
| cap_o | output | CNT_W | Snapshot of the count |

## Verification
A load, a restart or a wrapped count is visible on the count after the same edge that accepts the write or the step. A new run enable produces its first increment one edge later. A snapshot appears two edges after the capture write. The bench drives and samples only on falling edges, and it counts the elapsed rising edges from the write that starts each run. The expected count and wrap pulses after n steps come from closed-form arithmetic: n normal steps, plus floor(n/(K+1)) corrections, reduced by the wrap limit. The bench sweeps steps, correction intervals and limits, and it compares every cycle of every run.

// File: rtl/ptp_ns_timer_pkg.sv
package ptp_ns_timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_VALUE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
  localparam logic [ADDR_W-1:0] A_CORR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STEP   = 3'd4;

  localparam int CB_RUN     = 0;
  localparam int CB_WRAP_LO = 4;
  localparam int CB_WRAP_HI = 5;
  localparam int CB_EVT     = 7;
  localparam int CB_RESTART = 9;
  localparam int CB_SNAP    = 11;

  localparam int CORR_LSB = 8;
endpackage

// File: rtl/ptp_ns_timer_regs.sv
module ptp_ns_timer_regs
  import ptp_ns_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  rd_data,
  output logic              run,
  output logic              wrap_en,
  output logic              evt_en,
  output logic              load,
  output logic              restart,
  output logic              corr_wr,
  output logic              snap_pend,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  corr_per,
  output logic [STEP_W-1:0] step,
  output logic [STEP_W-1:0] corr_step,
  output logic [CNT_W-1:0]  cap_val
);
  logic              wr_ctrl, wr_per, wr_step;
  logic              run_q, run_d, wlo_q, wlo_d, whi_q, whi_d, evt_q, evt_d;
  logic              snap_q, snap_d;
  logic [CNT_W-1:0]  per_q, cper_q, cap_q, cap_d;
  logic [STEP_W-1:0] step_q, cstep_q;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_per  = wr_en && (wr_addr == A_PERIOD);
  assign wr_step = wr_en && (wr_addr == A_STEP);
  assign corr_wr = wr_en && (wr_addr == A_CORR);
  assign load    = wr_en && (wr_addr == A_VALUE);
  assign restart = wr_ctrl && wr_data[CB_RESTART];

  always_comb begin
    run_d  = run_q;
    wlo_d  = wlo_q;
    whi_d  = whi_q;
    evt_d  = evt_q;
    snap_d = 1'b0;
    if (wr_ctrl) begin
      run_d  = wr_data[CB_RUN];
      wlo_d  = wr_data[CB_WRAP_LO];
      whi_d  = wr_data[CB_WRAP_HI];
      evt_d  = wr_data[CB_EVT];
      snap_d = wr_data[CB_SNAP];
    end
    cap_d = snap_q ? cnt_i : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wlo_q  <= 1'b0;
      whi_q  <= 1'b0;
      evt_q  <= 1'b0;
      snap_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      run_q  <= run_d;
      wlo_q  <= wlo_d;
      whi_q  <= whi_d;
      evt_q  <= evt_d;
      snap_q <= snap_d;
      cap_q  <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
    end else if (wr_per) begin
      per_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cper_q <= '0;
    end else if (corr_wr) begin
      cper_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      cstep_q <= '0;
    end else if (wr_step) begin
      step_q  <= wr_data[STEP_W-1:0];
      cstep_q <= wr_data[CORR_LSB+STEP_W-1:CORR_LSB];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CB_RUN]     = run_q;
        rd_data[CB_WRAP_LO] = wlo_q;
        rd_data[CB_WRAP_HI] = whi_q;
        rd_data[CB_EVT]     = evt_q;
        rd_data[CB_SNAP]    = snap_q;
      end
      A_VALUE:  rd_data = cap_q;
      A_PERIOD: rd_data = per_q;
      A_CORR:   rd_data = cper_q;
      A_STEP: begin
        rd_data[STEP_W-1:0]                 = step_q;
        rd_data[CORR_LSB+STEP_W-1:CORR_LSB] = cstep_q;
      end
      default:  rd_data = '0;
    endcase
  end

  assign run       = run_q;
  assign wrap_en   = wlo_q && whi_q;
  assign evt_en    = evt_q;
  assign snap_pend = snap_q;
  assign period    = per_q;
  assign corr_per  = cper_q;
  assign step      = step_q;
  assign corr_step = cstep_q;
  assign cap_val   = cap_q;
endmodule

// File: rtl/ptp_ns_timer_corr.sv
module ptp_ns_timer_corr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             corr_wr,
  input  logic [CNT_W-1:0] corr_per,
  output logic             use_corr
);
  logic [CNT_W-1:0] phase_q, phase_d;
  logic             active, hit;

  assign active = (corr_per != '0);
  assign hit    = active && (phase_q == corr_per);

  always_comb begin
    phase_d = phase_q;
    if (corr_wr) begin
      phase_d = '0;
    end else if (run && active) begin
      phase_d = hit ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign use_corr = hit;
endmodule

// File: rtl/ptp_ns_timer_accum.sv
module ptp_ns_timer_accum #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic              restart,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              wrap_en,
  input  logic              evt_en,
  input  logic [CNT_W-1:0]  period,
  input  logic [STEP_W-1:0] step,
  input  logic [STEP_W-1:0] corr_step,
  input  logic              use_corr,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap,
  output logic              evt
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wrap_q, wrap_d, evt_q, evt_d;
  logic [STEP_W-1:0] add;
  logic [SUM_W-1:0]  sum, lim;
  logic              hit;

  always_comb begin
    add    = use_corr ? corr_step : step;
    sum    = {1'b0, cnt_q} + {{(SUM_W-STEP_W){1'b0}}, add};
    lim    = {1'b0, period};
    hit    = run && wrap_en && (sum >= lim);
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (run) begin
      if (hit) begin
        cnt_d  = CNT_W'(sum - lim);
        wrap_d = 1'b1;
      end else begin
        cnt_d = sum[CNT_W-1:0];
      end
    end
    evt_d = wrap_d && evt_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
      evt_q  <= evt_d;
    end
  end

  assign cnt  = cnt_q;
  assign wrap = wrap_q;
  assign evt  = evt_q;
endmodule

// File: rtl/ptp_ns_timer.sv
module ptp_ns_timer
  import ptp_ns_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o,
  output logic              evt_o,
  output logic [CNT_W-1:0]  cap_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              run, wrap_en, evt_en, load, restart, corr_wr, snap_pend, use_corr;
  logic [CNT_W-1:0]  period, corr_per;
  logic [STEP_W-1:0] step, corr_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  ptp_ns_timer_regs #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cnt_i(cnt_o), .rd_data(rd_data),
    .run(run), .wrap_en(wrap_en), .evt_en(evt_en), .load(load),
    .restart(restart), .corr_wr(corr_wr), .snap_pend(snap_pend),
    .period(period), .corr_per(corr_per), .step(step),
    .corr_step(corr_step), .cap_val(cap_o)
  );

  ptp_ns_timer_corr #(.CNT_W(CNT_W)) u_corr (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .corr_wr(corr_wr),
    .corr_per(corr_per), .use_corr(use_corr)
  );

  ptp_ns_timer_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .load(load),
    .restart(restart), .load_val(wr_data), .wrap_en(wrap_en),
    .evt_en(evt_en), .period(period), .step(step),
    .corr_step(corr_step), .use_corr(use_corr), .cnt(cnt_o),
    .wrap(wrap_o), .evt(evt_o)
  );
endmodule

// File: rtl/ptp_ns_timer_chk.sv
module ptp_ns_timer_chk
  import ptp_ns_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic              run,
  input logic              wrap_en,
  input logic [CNT_W-1:0]  period,
  input logic              snap_pend,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              wrap_o,
  input logic              evt_o,
  input logic [CNT_W-1:0]  cap_o
);
  logic ld_w, rs_w;
  assign ld_w = wr_en && (wr_addr == A_VALUE);
  assign rs_w = wr_en && (wr_addr == A_CTRL) && wr_data[CB_RESTART];

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_w && !rs_w) |=> $stable(cnt_o));

  // R7
  wrap_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && wrap_en && $stable(period)) |-> (cnt_o < period));

  // R8
  no_wrap_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_en |=> !wrap_o);

  // R9
  evt_needs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> wrap_o);

  // R10
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_w |=> (cnt_o == $past(wr_data)));

  // R11
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_w |=> (cnt_o == '0));

  // R12
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_pend |=> (cap_o == $past(cnt_o)));
endmodule

bind ptp_ns_timer ptp_ns_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .run(run), .wrap_en(wrap_en), .period(period),
  .snap_pend(snap_pend), .cnt_o(cnt_o), .wrap_o(wrap_o), .evt_o(evt_o),
  .cap_o(cap_o)
);

// File: tb/ptp_ns_timer_tb.sv
module ptp_ns_timer_tb;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [2:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data, cnt_o, cap_o;
  logic             wrap_o, evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptp_ns_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_o(cnt_o), .wrap_o(wrap_o), .evt_o(evt_o), .cap_o(cap_o)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input longint d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output longint v);
    rd_addr = a;
    #1;
    v = longint'(rd_data);
  endtask

  function automatic longint total(input longint n, input longint s,
                                   input longint c, input longint p);
    longint k;
    k = (p == 0) ? 0 : n / p;
    return n * s + k * (c - s);
  endfunction

  // Configure from a stopped state, start, and compare every cycle.
  task automatic run_cfg(input string req, input longint s, input longint c,
                         input longint p, input longint lim, input bit wrapon,
                         input bit evton, input int ncyc);
    longint ctrl, t, tp, ec;
    bit ew;
    wr(3'd0, 0);
    wr(3'd4, s | (c << 8));
    wr(3'd2, lim);
    wr(3'd3, (p == 0) ? 0 : p - 1);   // R6: phase restarts here
    wr(3'd1, 0);
    ctrl = 1 | (wrapon ? 48 : 16) | (evton ? 128 : 0);
    wr(3'd0, ctrl);
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      t  = total(n, s, c, p);
      tp = total(n - 1, s, c, p);
      if (wrapon) begin
        ec = t % lim;
        ew = (t / lim) != (tp / lim);
      end else begin
        ec = t & 64'hFFFF_FFFF;
        ew = 1'b0;
      end
      chk({req, " count"}, longint'(cnt_o), ec);
      chk({req, " wrap"}, longint'(wrap_o), longint'(ew));
      chk({req, " evt"}, longint'(evt_o), longint'(ew && evton));
    end
  endtask

  initial begin
    longint v, held, x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 count", longint'(cnt_o), 0);
    chk("R1 snapshot", longint'(cap_o), 0);
    chk("R1 wrap", longint'(wrap_o), 0);
    chk("R1 evt", longint'(evt_o), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 readback", v, 0);
    end

    // R3 R4 R7 R9: correction every 4th cycle, wrap at 100, events on
    run_cfg("R4/R7", 8, 9, 4, 100, 1'b1, 1'b1, 300);
    // R5 R9: correction disabled, events gated off
    run_cfg("R5 R9", 5, 20, 0, 64, 1'b1, 1'b0, 200);
    // R8: only one wrap bit set, count passes the limit
    run_cfg("R8", 7, 1, 2, 50, 1'b0, 1'b1, 60);
    // R3 R6: near-exhaustive sweep of steps and intervals
    for (int p = 2; p <= 7; p++) begin
      for (int s = 1; s <= 3; s++) begin
        run_cfg("R3 R6 sweep", s, s + p, p, 37, 1'b1, 1'b1, 40);
      end
    end

    // R2: stop and hold
    wr(3'd0, 0);
    held = longint'(cnt_o);
    repeat (10) @(negedge clk);
    chk("R2 hold", longint'(cnt_o), held);

    // R10: load while stopped and while running
    wr(3'd1, 12345);
    chk("R10 load stopped", longint'(cnt_o), 12345);
    wr(3'd4, 3);
    wr(3'd3, 0);
    wr(3'd2, 32'h8000_0000);
    wr(3'd0, 49);
    repeat (5) @(negedge clk);
    chk("R10 run before load", longint'(cnt_o), 12345 + 15);
    wr(3'd1, 32'h7FFF_FFFE);
    chk("R10 load running", longint'(cnt_o), 32'h7FFF_FFFE);
    @(negedge clk);
    chk("R7 wrap at 2^31", longint'(cnt_o), 1);
    chk("R7 wrap pulse", longint'(wrap_o), 1);

    // R12: snapshot of a running count
    wr(3'd0, 49 | (1 << 11));
    x = longint'(cnt_o);
    rd(3'd0, v);
    chk("R12 pending bit", (v >> 11) & 1, 1);
    @(negedge clk);
    chk("R12 snapshot", longint'(cap_o), x);
    rd(3'd1, v);
    chk("R12 value read", v, x);
    rd(3'd0, v);
    chk("R12 bit cleared", (v >> 11) & 1, 0);

    // R11: restart while running
    repeat (3) @(negedge clk);
    wr(3'd0, 49 | (1 << 9));
    chk("R11 zeroed", longint'(cnt_o), 0);
    rd(3'd0, v);
    chk("R11 bit reads 0", (v >> 9) & 1, 0);
    @(negedge clk);
    chk("R11 resumes", longint'(cnt_o), 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule